// File: doc/BRIEF.md
# Bit-Addressed Carry Logic Unit

This unit carries out the single-bit carry instructions of an 8-bit processor, one bus cycle at a time. Each instruction has a 16-bit operand. The operand packs a 3-bit bit index into its top bits and a 13-bit byte address into the rest. Once it accepts an instruction, the unit performs these steps in order:

- reads the two operand bytes from the program counter onward;
- reads the addressed byte;
- either folds the chosen bit into the carry flag or flips that bit in memory and writes the byte back.

The surrounding core drives `go` for one cycle, along with the opcode and the program counter of the operand. The carry flag stays in the core. The unit reads it on `c_in` and returns a new value on `c_out`, qualified by `c_we`. Memory is a synchronous bus: read data appears on `mem_rdata` in the cycle after `mem_rd`, and writes take effect at the clock edge.

Count the edge that samples `go` as edge 0:
- Cycle 1 fetches the low operand byte.
- Cycle 2 fetches the high operand byte.
- Cycle 3 reads the data byte.
- Cycle 4 ends the AND forms and the flip. For the OR and XOR forms, cycle 4 is an idle bus cycle, and the instruction ends in cycle 5.

Top module: `bitc_unit`

## Requirements
- R1: After a synchronous active-high reset, `busy`, `done`, `c_we`, `mem_rd` and `mem_wr` are all 0.
- R2: After `go` is accepted, cycle 1 reads address `pc` and cycle 2 reads address `pc+1`. The first byte returned is the operand low byte and the second is the operand high byte.
- R3: In cycle 3 the unit reads address `{3'b000, operand[12:0]}`. `operand[15:13]` selects the bit, with 0 meaning the least significant bit.
- R4: Opcode 0x4A sets carry to `c_in & bit`, and opcode 0x6A sets carry to `c_in & ~bit`. Both assert `done` and `c_we` in cycle 4.
- R5: Opcode 0x0A sets carry to `c_in | bit`, and opcode 0x2A sets carry to `c_in | ~bit`. For both, cycle 4 has no bus access, and `done` and `c_we` are asserted in cycle 5.
- R6: Opcode 0x8A sets carry to `c_in ^ bit`. Cycle 4 is idle, and the result appears in cycle 5.
- R7: Opcode 0xEA writes the data byte with the selected bit inverted back to `{3'b000, operand[12:0]}` in cycle 4. `done` is asserted in the same cycle, and `c_we` stays 0.
- R8: `go` with any other opcode is ignored. `go` while `busy` is 1 is ignored, and the running instruction finishes unchanged.
- R9: Each cycle has at most one bus access. `done` lasts exactly one cycle, and `busy` returns to 0 in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start an instruction (one-cycle pulse) |
| opcode | input | 8 | Opcode of the instruction to execute |
| pc | input | 16 | Address of the first operand byte |
| c_in | input | 1 | Current carry flag |
| c_out | output | 1 | New carry value; equals `c_in` when `c_we` is 0 |
| c_we | output | 1 | Carry write enable |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | Final cycle of an instruction |
| mem_addr | output | 16 | Bus address |
| mem_rd | output | 1 | Bus read strobe; data arrives the following cycle |
| mem_wr | output | 1 | Bus write strobe |
| mem_wdata | output | 8 | Bus write data |
| mem_rdata | input | 8 | Bus read data |

## Verification
The hardest case to reach is an operand whose high byte is all ones: bit index 7 together with address 0x1FFF. Here the index bits and the address bits are adjacent in the same byte, so a wrong split leaks into the upper bus address. The bench sweeps every opcode against every bit index, every carry input, and data bytes with the chosen bit both set and clear. It alternates the address between 0x1FFF, 0x0000 and mixed patterns, so the fully-set high byte appears under every opcode. A second `go` with a different opcode is also issued in the middle of an instruction, to show that it is dropped.

// File: rtl/bitc_pkg.sv
package bitc_pkg;
    localparam int DW = 8;           // data byte width
    localparam int AW = 16;          // bus address / operand width
    localparam int IW = 3;           // bit index width
    localparam int LW = AW - IW;     // byte address width inside the operand
    localparam int HW = LW - DW;     // address bits carried by the high byte

    localparam logic [7:0] OPC_AND  = 8'h4A;
    localparam logic [7:0] OPC_ANDN = 8'h6A;
    localparam logic [7:0] OPC_OR   = 8'h0A;
    localparam logic [7:0] OPC_ORN  = 8'h2A;
    localparam logic [7:0] OPC_XOR  = 8'h8A;
    localparam logic [7:0] OPC_FLIP = 8'hEA;

    typedef enum logic [2:0] {
        K_AND, K_ANDN, K_OR, K_ORN, K_XOR, K_FLIP
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_FLO, S_FHI, S_RD, S_POST, S_TAIL
    } st_e;

    typedef struct packed {
        logic  ok;     // recognised opcode
        kind_e kind;   // operation
        logic  slow;   // idle cycle after the data read
    } dec_t;

    function automatic dec_t decode(input logic [7:0] op);
        dec_t d;
        d = '{ok: 1'b1, kind: K_AND, slow: 1'b0};
        case (op)
            OPC_AND:  d.kind = K_AND;
            OPC_ANDN: d.kind = K_ANDN;
            OPC_OR:   begin d.kind = K_OR;  d.slow = 1'b1; end
            OPC_ORN:  begin d.kind = K_ORN; d.slow = 1'b1; end
            OPC_XOR:  begin d.kind = K_XOR; d.slow = 1'b1; end
            OPC_FLIP: d.kind = K_FLIP;
            default:  d.ok = 1'b0;
        endcase
        return d;
    endfunction

    function automatic logic pick(input logic [DW-1:0] b, input logic [IW-1:0] i);
        return b[i];
    endfunction
endpackage

// File: rtl/bitc_decode.sv
module bitc_decode
    import bitc_pkg::*;
(
    input  logic [7:0] opcode,
    output dec_t       dec
);
    always_comb dec = decode(opcode);
endmodule

// File: rtl/bitc_alu.sv
module bitc_alu
    import bitc_pkg::*;
(
    input  kind_e          kind,
    input  logic [IW-1:0]  idx,
    input  logic [DW-1:0]  byte_in,
    input  logic           c_in,
    output logic           c_new,
    output logic [DW-1:0]  byte_out
);
    logic sel;

    always_comb begin
        sel      = pick(byte_in, idx);
        byte_out = byte_in ^ (DW'(1) << idx);
        case (kind)
            K_AND:   c_new = c_in & sel;
            K_ANDN:  c_new = c_in & ~sel;
            K_OR:    c_new = c_in | sel;
            K_ORN:   c_new = c_in | ~sel;
            K_XOR:   c_new = c_in ^ sel;
            default: c_new = c_in;
        endcase
    end
endmodule

// File: rtl/bitc_seq.sv
module bitc_seq
    import bitc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           go,
    input  dec_t           dec,
    input  logic [AW-1:0]  pc,
    input  logic [DW-1:0]  mem_rdata,
    output logic [AW-1:0]  mem_addr,
    output logic           mem_rd,
    output logic           mem_wr,
    output kind_e          kind,
    output logic [IW-1:0]  idx,
    output logic [DW-1:0]  cur_byte,
    output logic           exec,
    output logic           busy
);
    st_e           st;
    kind_e         kind_q;
    logic          slow_q;
    logic [AW-1:0] pc_q;
    logic [DW-1:0] lo_q;
    logic [AW-1:0] opw_q;
    logic [DW-1:0] byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            kind_q <= K_AND;
            slow_q <= 1'b0;
            pc_q   <= '0;
            lo_q   <= '0;
            opw_q  <= '0;
            byte_q <= '0;
        end else begin
            case (st)
                S_IDLE: if (go && dec.ok) begin
                    kind_q <= dec.kind;
                    slow_q <= dec.slow;
                    pc_q   <= pc;
                    st     <= S_FLO;
                end
                S_FLO:  st <= S_FHI;
                S_FHI:  begin lo_q <= mem_rdata; st <= S_RD; end
                S_RD:   begin opw_q <= {mem_rdata, lo_q}; st <= S_POST; end
                S_POST: begin byte_q <= mem_rdata; st <= slow_q ? S_TAIL : S_IDLE; end
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_rd   = (st == S_FLO) || (st == S_FHI) || (st == S_RD);
        mem_wr   = (st == S_POST) && (kind_q == K_FLIP);
        case (st)
            S_FLO:   mem_addr = pc_q;
            S_FHI:   mem_addr = pc_q + AW'(1);
            S_RD:    mem_addr = {{IW{1'b0}}, mem_rdata[HW-1:0], lo_q};
            S_POST:  mem_addr = {{IW{1'b0}}, opw_q[LW-1:0]};
            default: mem_addr = '0;
        endcase
        cur_byte = (st == S_POST) ? mem_rdata : byte_q;
        exec     = ((st == S_POST) && !slow_q) || (st == S_TAIL);
        busy     = (st != S_IDLE);
        kind     = kind_q;
        idx      = opw_q[AW-1:LW];
    end

    // R2: operand low byte is fetched from the captured program counter
    p_fetch_lo_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && go && dec.ok) |=> (mem_rd && mem_addr == $past(pc)));
    // R2: high byte follows at the next address
    p_fetch_hi_r2: assert property (@(posedge clk) disable iff (rst)
        (st == S_FLO) |=> (mem_rd && mem_addr == $past(mem_addr) + AW'(1)));
    // R3: data accesses keep the index bits off the bus
    p_hi_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (st == S_RD || mem_wr) |-> (mem_addr[AW-1:LW] == '0));
    // R5: idle bus cycle for the OR and XOR forms
    p_idle_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (st == S_POST && slow_q) |-> (!mem_rd && !mem_wr && !exec));
    // R9: one access per cycle
    p_one_access_r9: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
    // R8: a second go while busy does not alter the latched operation
    p_hold_kind_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(kind_q));
endmodule

// File: rtl/bitc_unit.sv
module bitc_unit
    import bitc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           go,
    input  logic [7:0]     opcode,
    input  logic [AW-1:0]  pc,
    input  logic           c_in,
    output logic           c_out,
    output logic           c_we,
    output logic           busy,
    output logic           done,
    output logic [AW-1:0]  mem_addr,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata
);
    dec_t          dec;
    kind_e         kind;
    logic [IW-1:0] idx;
    logic [DW-1:0] cur_byte;
    logic          exec;
    logic          c_new;

    bitc_decode u_dec (.opcode(opcode), .dec(dec));

    bitc_seq u_seq (
        .clk(clk), .rst(rst), .go(go), .dec(dec), .pc(pc),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .kind(kind), .idx(idx), .cur_byte(cur_byte),
        .exec(exec), .busy(busy)
    );

    bitc_alu u_alu (
        .kind(kind), .idx(idx), .byte_in(cur_byte), .c_in(c_in),
        .c_new(c_new), .byte_out(mem_wdata)
    );

    always_comb begin
        done  = exec;
        c_we  = exec && (kind != K_FLIP);
        c_out = c_we ? c_new : c_in;
    end

    // R7: the flip form never writes the carry
    p_flip_no_carry_r7: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (!c_we && done));
    // R9: done is a single-cycle pulse followed by idle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));
    // R4: carry is only written at the end of an instruction
    p_we_at_end_r4: assert property (@(posedge clk) disable iff (rst)
        c_we |-> done);
endmodule

// File: tb/sim_bitc_unit.sv
module sim_bitc_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        go = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] pc = 16'h0000;
    logic        c_in = 1'b0;
    logic        c_out, c_we, busy, done, mem_rd, mem_wr;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;

    int n_chk = 0;
    int n_bad = 0;
    bit wd_hit = 0;

    // bus responder state
    logic [15:0] t_pc = 16'hF000;
    logic [7:0]  t_lo = 8'h00, t_hi = 8'h00, t_data = 8'h00;
    logic [12:0] t_a13 = 13'h0;

    always #10 clk = ~clk;   // 50 MHz

    bitc_unit u0 (
        .clk(clk), .rst(rst), .go(go), .opcode(opcode), .pc(pc), .c_in(c_in),
        .c_out(c_out), .c_we(c_we), .busy(busy), .done(done),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_rd) begin
            if (mem_addr == t_pc)                    mem_rdata <= t_lo;
            else if (mem_addr == t_pc + 16'd1)       mem_rdata <= t_hi;
            else if (mem_addr == {3'b000, t_a13})    mem_rdata <= t_data;
            else                                     mem_rdata <= 8'h00;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(!busy && !done && !c_we && !mem_rd && !mem_wr, "R1", "reset outputs",
            {busy, done, c_we, mem_rd, mem_wr}, 0);
    endtask

    // One instruction; optional second go (other opcode) injected in cycle 2.
    task automatic run_op(input logic [7:0] op, input logic [2:0] b,
                          input logic [12:0] a13, input logic [7:0] d,
                          input logic cin, input bit inject);
        bit sel, slow, flip, exp_c;
        string rq;
        sel  = d[b];
        slow = (op == 8'h0A) || (op == 8'h2A) || (op == 8'h8A);
        flip = (op == 8'hEA);
        case (op)
            8'h4A: begin exp_c = cin & sel;  rq = "R4"; end
            8'h6A: begin exp_c = cin & ~sel; rq = "R4"; end
            8'h0A: begin exp_c = cin | sel;  rq = "R5"; end
            8'h2A: begin exp_c = cin | ~sel; rq = "R5"; end
            8'h8A: begin exp_c = cin ^ sel;  rq = "R6"; end
            default: begin exp_c = cin;      rq = "R7"; end
        endcase
        t_pc = 16'hF000 + {8'h00, a13[7:0]};
        t_a13 = a13; t_lo = a13[7:0]; t_hi = {b, a13[12:8]}; t_data = d;
        pc = t_pc; c_in = cin; opcode = op; go = 1'b1;
        @(negedge clk); go = 1'b0;                           // cycle 1
        chk(mem_rd && !mem_wr && mem_addr == t_pc, "R2", "low fetch addr", mem_addr, t_pc);
        if (inject) begin opcode = 8'h4A ^ op ^ 8'hEA; pc = 16'h1234; go = 1'b1; end
        @(negedge clk); go = 1'b0;                           // cycle 2
        chk(mem_rd && mem_addr == t_pc + 16'd1, "R2", "high fetch addr", mem_addr, t_pc + 16'd1);
        @(negedge clk);                                      // cycle 3
        chk(mem_rd && mem_addr == {3'b000, a13}, "R3", "data addr", mem_addr, {3'b000, a13});
        @(negedge clk);                                      // cycle 4
        if (flip) begin
            chk(mem_wr && done && !c_we && mem_addr == {3'b000, a13}
                && mem_wdata == (d ^ (8'h01 << b)), "R7", "flip write",
                {mem_wr, done, c_we, mem_addr, mem_wdata},
                {3'b110, 3'b000, a13, d ^ (8'h01 << b)});
            chk(c_out == cin, "R7", "carry kept", c_out, cin);
        end else if (!slow) begin
            chk(done && c_we && c_out == exp_c && !mem_rd, rq, "and result",
                {done, c_we, c_out}, {2'b11, exp_c});
        end else begin
            chk(!done && !mem_rd && !mem_wr, "R5", "idle gap", {done, mem_rd, mem_wr}, 0);
            @(negedge clk);                                  // cycle 5
            chk(done && c_we && c_out == exp_c, rq, "slow result",
                {done, c_we, c_out}, {2'b11, exp_c});
        end
        @(negedge clk);
        chk(!busy && !done && !mem_rd && !mem_wr, inject ? "R8" : "R9", "back to idle",
            {busy, done, mem_rd, mem_wr}, 0);
    endtask

    task automatic sweep_all();
        logic [7:0] ops [6] = '{8'h4A, 8'h6A, 8'h0A, 8'h2A, 8'h8A, 8'hEA};
        logic [12:0] addrs [3] = '{13'h1FFF, 13'h0000, 13'h0A5C};
        int k = 0;
        for (int o = 0; o < 6; o++)
            for (int b = 0; b < 8; b++)
                for (int c = 0; c < 2; c++)
                    for (int s = 0; s < 2; s++) begin
                        logic [7:0] d;
                        d = s ? (8'h01 << b) : ~(8'h01 << b);
                        run_op(ops[o], 3'(b), addrs[k % 3], d, c[0], 1'b0);
                        k++;
                    end
    endtask

    task automatic bad_opcode();
        opcode = 8'h4B; go = 1'b1;
        @(negedge clk); go = 1'b0;
        chk(!busy && !mem_rd, "R8", "unknown opcode ignored", {busy, mem_rd}, 0);
        opcode = 8'hEB; go = 1'b1;
        @(negedge clk); go = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_rd && !mem_wr, "R8", "unknown opcode ignored 2",
            {busy, mem_rd, mem_wr}, 0);
    endtask

    task automatic go_while_busy();
        // R8: injected go mid-instruction must not change results or restart
        run_op(8'h4A, 3'd7, 13'h1FFF, 8'h80, 1'b1, 1'b1);
        run_op(8'h0A, 3'd0, 13'h1FFF, 8'h00, 1'b0, 1'b1);
        run_op(8'hEA, 3'd3, 13'h0001, 8'hFF, 1'b1, 1'b1);
    endtask

    initial begin
        #(200000 * 20);
        wd_hit = 1;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        bad_opcode();
        sweep_all();
        go_while_busy();
        do_reset();
        if (!wd_hit) begin
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule